// File: doc/BRIEF.md
# Coincidence Trigger and Hold Sequencer

This block is the event controller of a multi-channel front-end readout. While idle it watches the per-channel comparator flags. When any enabled channel fires, it records that channel and pulls an active-low service request low, so that a host can start the master clock on demand. Two windows then run. The collection window (A) lets further channels join the event. The coincidence window (B) waits for an external coincidence pulse and gives the shapers time to reach their peak.

When window B expires and a coincidence was seen, the block raises hold. It then steps through the recorded channels, lowest address first, one per master-clock cycle. Each step presents the channel address with a valid strobe. When window B expires without a coincidence, the block instead issues a fixed-length reset pulse to the logic and the peak detectors and discards the event. After either outcome it returns to waiting.

The FSM has four states. `ST_IDLE` waits for an enabled hit. `ST_COLLECT` runs both windows. `ST_SCAN` holds and multiplexes. `ST_PURGE` drives the reset pulse. The transitions are:

- detect: `ST_IDLE` to `ST_COLLECT`
- accept: `ST_COLLECT` to `ST_SCAN`, on expiry with a coincidence
- reject: `ST_COLLECT` to `ST_PURGE`, on expiry without a coincidence
- drain: `ST_SCAN` to `ST_IDLE`, when the list is empty
- recover: `ST_PURGE` to `ST_IDLE`, when the pulse is complete

Top module: `coinc_hold_seq`

## Requirements
- R1: After reset, `srq_n` is 1 and `hold`, `lch_rst` and `addr_vld` are 0.
- R2: A rising edge in idle with any bit of `ch_trig & ch_en` high detects an event. Those channels are recorded, and `srq_n` is low from that edge until the edge that returns the block to idle.
- R3: A channel whose `ch_en` bit is 0 never starts an event and is never recorded or read out.
- R4: Call the detecting edge edge 0. On edge k (k ≥ 1), channels with `ch_trig & ch_en` high join the list only if 2·(k−1) < `gate_a` and window B does not expire on that edge. This models counting both clock edges from the first falling edge after detection.
- R5: Window B expires on edge max(`win_b`, 1) after detection. `hold` and `lch_rst` stay 0 before that edge.
- R6: If `coinc` is high on any edge from edge 0 through the expiry edge, `hold` is 1 after the expiry edge.
- R7: Without a coincidence, `lch_rst` is 1 for exactly RST_CYC cycles starting after the expiry edge. The recorded list is cleared, and `srq_n` returns to 1 when `lch_rst` falls.
- R8: From the edge after the accepting expiry, each cycle presents one recorded channel on `mux_addr` with `addr_vld` = 1, in ascending channel number.
- R9: On the edge after the last recorded channel has been presented, `hold` and `addr_vld` go to 0 and `srq_n` goes to 1.
- R10: Channel triggers during the scan or the reset pulse are ignored. They neither extend the list nor start a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_trig | input | NCH | Per-channel comparator flags |
| ch_en | input | NCH | Per-channel enable mask (1 = enabled) |
| coinc | input | 1 | External coincidence pulse |
| gate_a | input | GATE_W | Collection window length, in clock edges |
| win_b | input | WINB_W | Coincidence window length, in rising edges |
| srq_n | output | 1 | Active-low service request |
| hold | output | 1 | Peak-hold command |
| lch_rst | output | 1 | Reset to logic and peak detectors |
| mux_addr | output | AW | Address of the channel being presented |
| addr_vld | output | 1 | `mux_addr` is valid this cycle |

## Verification
The bench uses the default build: eight channels, a 3-bit gate and a 4-bit window B, and a two-cycle reset pulse. Eight channels are enough to cover non-adjacent sparse lists, a masked channel alongside an enabled one, and an out-of-window channel that sorts after the accepted ones. With a 4-bit window B, the bench can test a window longer than the widest gate of seven edges, as well as the zero setting that is treated as one edge.

// File: rtl/coinc_hold_seq_pkg.sv
package coinc_hold_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_SCAN    = 2'd2,
        ST_PURGE   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/chs_window_ctr.sv
module chs_window_ctr #(
    parameter int GATE_W = 3,
    parameter int WINB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [GATE_W-1:0] gate_a,
    input  logic [WINB_W-1:0] win_b,
    output logic              acc_a,
    output logic              exp_b
);
    localparam int CW = (((WINB_W + 1) > GATE_W) ? (WINB_W + 1) : GATE_W) + 1;

    logic [WINB_W-1:0] cnt;
    logic [CW-1:0]     half_edges;
    logic [CW-1:0]     gate_x;
    logic [CW-1:0]     cnt_p1;
    logic [CW-1:0]     winb_eff;

    // cnt holds k-1 on edge k after detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        half_edges = {{(CW-WINB_W-1){1'b0}}, cnt, 1'b0};
        gate_x     = {{(CW-GATE_W){1'b0}}, gate_a};
        cnt_p1     = {{(CW-WINB_W){1'b0}}, cnt} + 1'b1;
        winb_eff   = (win_b == '0) ? CW'(1) : {{(CW-WINB_W){1'b0}}, win_b};
        exp_b      = run && (cnt_p1 >= winb_eff);
        acc_a      = run && !exp_b && (half_edges < gate_x);
    end
endmodule

// File: rtl/chs_chan_latch.sv
module chs_chan_latch #(
    parameter int NCH = 8,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hits,
    input  logic           load,
    input  logic           add,
    input  logic           clr,
    input  logic           drop,
    input  logic [AW-1:0]  drop_idx,
    output logic [NCH-1:0] pending
);
    for (genvar i = 0; i < NCH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[i] <= 1'b0;
            end else if (clr) begin
                pending[i] <= 1'b0;
            end else if (load) begin
                pending[i] <= hits[i];
            end else if (add) begin
                pending[i] <= pending[i] | hits[i];
            end else if (drop && (drop_idx == AW'(i))) begin
                pending[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/chs_low_pick.sv
module chs_low_pick #(
    parameter int NCH = 8,
    parameter int AW  = 3
) (
    input  logic [NCH-1:0] req,
    output logic           found,
    output logic [AW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end
endmodule

// File: rtl/coinc_hold_seq.sv
module coinc_hold_seq
    import coinc_hold_seq_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int GATE_W  = 3,
    parameter int WINB_W  = 4,
    parameter int RST_CYC = 2,
    localparam int AW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_trig,
    input  logic [NCH-1:0]    ch_en,
    input  logic              coinc,
    input  logic [GATE_W-1:0] gate_a,
    input  logic [WINB_W-1:0] win_b,
    output logic              srq_n,
    output logic              hold,
    output logic              lch_rst,
    output logic [AW-1:0]     mux_addr,
    output logic              addr_vld
);
    localparam int RCW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    seq_state_t     state, state_d;
    logic [NCH-1:0] hits;
    logic           any_hit;
    logic           start;
    logic           run;
    logic           acc_a;
    logic           exp_b;
    logic           coinc_seen;
    logic           coinc_ok;
    logic [NCH-1:0] pending;
    logic           found;
    logic [AW-1:0]  pick_idx;
    logic           scan_step;
    logic           purge_go;
    logic [RCW-1:0] rcnt;
    logic           rdone;

    assign hits      = ch_trig & ch_en;
    assign any_hit   = |hits;
    assign start     = (state == ST_IDLE) && any_hit;
    assign run       = (state == ST_COLLECT);
    assign coinc_ok  = coinc_seen | coinc;
    assign scan_step = (state == ST_SCAN) && found;
    assign purge_go  = run && exp_b && !coinc_ok;
    assign rdone     = (rcnt == RCW'(RST_CYC - 1));

    chs_window_ctr #(
        .GATE_W (GATE_W),
        .WINB_W (WINB_W)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run),
        .gate_a (gate_a),
        .win_b  (win_b),
        .acc_a  (acc_a),
        .exp_b  (exp_b)
    );

    chs_chan_latch #(
        .NCH (NCH),
        .AW  (AW)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits     (hits),
        .load     (start),
        .add      (acc_a),
        .clr      (purge_go),
        .drop     (scan_step),
        .drop_idx (pick_idx),
        .pending  (pending)
    );

    chs_low_pick #(
        .NCH (NCH),
        .AW  (AW)
    ) u_pick (
        .req   (pending),
        .found (found),
        .idx   (pick_idx)
    );

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (any_hit) state_d = ST_COLLECT;
            ST_COLLECT: if (exp_b) state_d = coinc_ok ? ST_SCAN : ST_PURGE;
            ST_SCAN:    if (!found) state_d = ST_IDLE;
            ST_PURGE:   if (rdone) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and event bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            coinc_seen <= 1'b0;
            rcnt       <= '0;
        end else begin
            state <= state_d;
            if (start) begin
                coinc_seen <= coinc;
            end else if (run) begin
                coinc_seen <= coinc_ok;
            end
            if (state == ST_PURGE) begin
                rcnt <= rcnt + 1'b1;
            end else begin
                rcnt <= '0;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srq_n    <= 1'b1;
            hold     <= 1'b0;
            lch_rst  <= 1'b0;
            addr_vld <= 1'b0;
            mux_addr <= '0;
        end else begin
            srq_n    <= (state_d == ST_IDLE);
            hold     <= (state_d == ST_SCAN);
            lch_rst  <= (state_d == ST_PURGE);
            addr_vld <= scan_step;
            if (scan_step) begin
                mux_addr <= pick_idx;
            end
        end
    end
endmodule

// File: rtl/coinc_hold_seq_chk.sv
module coinc_hold_seq_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srq_n,
    input logic          hold,
    input logic          lch_rst,
    input logic [AW-1:0] mux_addr,
    input logic          addr_vld
);
    // R7
    hold_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && lch_rst));

    // R8
    vld_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |-> hold);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srq_n |-> (!hold && !lch_rst && !addr_vld));

    // R6
    hold_in_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> (!srq_n && !addr_vld));

    // R8
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && $past(addr_vld)) |-> (mux_addr > $past(mux_addr)));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (srq_n && !addr_vld));
endmodule

bind coinc_hold_seq coinc_hold_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srq_n    (srq_n),
    .hold     (hold),
    .lch_rst  (lch_rst),
    .mux_addr (mux_addr),
    .addr_vld (addr_vld)
);

// File: tb/coinc_hold_seq_tb.sv
`timescale 1ns/1ps
module coinc_hold_seq_tb;
    localparam int NCH = 8;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ch_trig = '0;
    logic [NCH-1:0] ch_en = '1;
    logic           coinc = 1'b0;
    logic [2:0]     gate_a = '0;
    logic [3:0]     win_b = '0;
    logic           srq_n, hold, lch_rst, addr_vld;
    logic [AW-1:0]  mux_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    coinc_hold_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ch_trig(ch_trig), .ch_en(ch_en),
        .coinc(coinc), .gate_a(gate_a), .win_b(win_b), .srq_n(srq_n),
        .hold(hold), .lch_rst(lch_rst), .mux_addr(mux_addr), .addr_vld(addr_vld)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive inputs for the next rising edge, then return at the following falling edge
    task automatic tick(logic [NCH-1:0] t, logic c);
        ch_trig = t;
        coinc   = c;
        @(negedge clk);
    endtask

    task automatic expect_addr(string req, int a);
        check(req, "addr_vld", addr_vld, 1);
        check(req, "mux_addr", mux_addr, a);
    endtask

    task automatic t_reset();
        check("R1", "srq_n", srq_n, 1);
        check("R1", "hold", hold, 0);
        check("R1", "lch_rst", lch_rst, 0);
        check("R1", "addr_vld", addr_vld, 0);
    endtask

    task automatic t_collect_scan();
        ch_en = 8'hFF; gate_a = 3'd3; win_b = 4'd5;
        tick(8'h04, 0);                          // edge 0
        check("R2", "srq_n", srq_n, 0);
        tick(8'h20, 0);                          // edge 1 accepted
        tick(8'h02, 0);                          // edge 2 accepted
        tick(8'h80, 1);                          // edge 3: window A closed
        tick(8'h00, 0);                          // edge 4
        check("R5", "hold early", hold, 0);
        tick(8'h00, 0);                          // edge 5 expiry
        check("R6", "hold", hold, 1);
        check("R6", "addr_vld", addr_vld, 0);
        tick(8'h00, 0);  expect_addr("R8", 1);
        tick(8'h08, 0);  expect_addr("R10", 2);  // trigger during scan
        tick(8'h00, 0);  expect_addr("R4", 5);
        tick(8'h00, 0);
        check("R4", "addr_vld after list", addr_vld, 0);
        check("R9", "hold", hold, 0);
        check("R9", "srq_n", srq_n, 1);
        tick(8'h00, 0);
        check("R10", "srq_n", srq_n, 1);
    endtask

    task automatic t_mask();
        ch_en = 8'hF0; gate_a = 3'd0; win_b = 4'd2;
        tick(8'h0F, 0);
        check("R3", "srq_n masked", srq_n, 1);
        tick(8'h11, 1);                          // edge 0
        tick(8'h20, 0);                          // edge 1: gate 0 rejects
        tick(8'h00, 0);                          // edge 2 expiry
        check("R6", "hold", hold, 1);
        tick(8'h00, 0);  expect_addr("R3", 4);
        tick(8'h00, 0);
        check("R4", "addr_vld gate0", addr_vld, 0);
        check("R9", "srq_n", srq_n, 1);
    endtask

    task automatic t_purge();
        ch_en = 8'hFF; gate_a = 3'd3; win_b = 4'd3;
        tick(8'h01, 0);
        tick(8'h02, 0);
        tick(8'h00, 0);
        tick(8'h00, 0);                          // edge 3 expiry
        check("R7", "lch_rst", lch_rst, 1);
        check("R7", "hold", hold, 0);
        check("R7", "srq_n", srq_n, 0);
        tick(8'h04, 0);                          // trigger during pulse
        check("R7", "lch_rst 2nd", lch_rst, 1);
        tick(8'h00, 0);
        check("R7", "lch_rst end", lch_rst, 0);
        check("R7", "srq_n end", srq_n, 1);
        tick(8'h00, 0);
        check("R10", "srq_n after pulse", srq_n, 1);
        tick(8'h10, 1);
        tick(8'h00, 0);
        tick(8'h00, 0);
        tick(8'h00, 0);
        check("R6", "hold", hold, 1);
        tick(8'h00, 0);  expect_addr("R7", 4);
        tick(8'h00, 0);
        check("R7", "cleared list", addr_vld, 0);
    endtask

    task automatic t_long();
        ch_en = 8'hFF; gate_a = 3'd7; win_b = 4'd10;
        tick(8'h01, 0);                          // edge 0
        tick(8'h00, 0); tick(8'h00, 0); tick(8'h00, 0);
        tick(8'h08, 0);                          // edge 4 accepted
        tick(8'h10, 0);                          // edge 5 rejected
        tick(8'h00, 0); tick(8'h00, 0); tick(8'h00, 0);
        tick(8'h00, 0);                          // edge 9
        check("R5", "hold edge9", hold, 0);
        check("R5", "lch_rst edge9", lch_rst, 0);
        tick(8'h00, 1);                          // edge 10 expiry with coinc
        check("R5", "hold edge10", hold, 1);
        tick(8'h00, 0);  expect_addr("R8", 0);
        tick(8'h00, 0);  expect_addr("R4", 3);
        tick(8'h00, 0);
        check("R4", "gate7 end", addr_vld, 0);
    endtask

    task automatic t_zero_winb();
        ch_en = 8'hFF; gate_a = 3'd5; win_b = 4'd0;
        tick(8'h02, 0);
        tick(8'h01, 1);                          // edge 1 expiry
        check("R5", "hold winb0", hold, 1);
        tick(8'h00, 0);  expect_addr("R5", 1);
        tick(8'h00, 0);
        check("R9", "addr_vld", addr_vld, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_collect_scan();
        t_mask();
        t_purge();
        t_long();
        t_zero_winb();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule